// File: doc/BRIEF.md
# Transmit Output Tri-State Controller

This block decides, for every transmit channel of a multi-channel line interface, whether the line driver may drive the line or must sit in high impedance. It gathers chip-wide conditions into one global hold-off: the output-enable pin, a stalled master clock, a power-on reset, a qualified hardware reset pulse and a software reset pulse. It also gathers channel-local conditions into one hold-off per channel: a per-channel enable bit, a stalled transmit clock, power-down, channel reset and over-current shutdown. A driver is enabled only when neither hold-off is active. The enable is registered, so each driver-enable line changes only at a clock edge.

The block runs on a free-running control clock at the reference rate, which is 1.544 MHz for T1/J1 and 2.048 MHz for E1. The master clock and each transmit clock enter as plain signals. Each one passes through a synchronizer and then feeds a counter that flags the clock as lost once no edge has been seen for a parameterised number of cycles. The transmit-clock check is applied only for non-return-to-zero formats. It is skipped while the channel loops the line back or sends an internally generated pattern on the reference clock. When power-down is released, a channel waits out a recovery window before it reports itself ready and drives again.

Top module: `txo_hiz_ctrl`

## Requirements
- R1: While `por_n` is low, `drv_en`, `mf_en` and `tx_ready` are all 0. Once `por_n` is high, the master clock toggles and no hold-off condition is present, every bit of all three outputs reaches 1 within a few cycles.
- R2: When `oe_pin` is 0 at a clock edge, every bit of `drv_en` is 0 after that edge.
- R3: If `hw_rst_n` stays low for more than RST_MIN_CYC consecutive cycles, all drivers go to high impedance until the pin returns high. A shorter low pulse changes no output. A one-cycle `sw_rst` pulse forces all drivers off from the next edge and for SWRST_CYC further cycles.
- R4: When `ch_oe[i]` is 0, `drv_en[i]` is 0 after the next edge, and the other channels are not affected.
- R5: If `tx_clk[i]` shows no transition for TXCLK_LOSS_CYC cycles while the 2-bit format field `tx_fmt[2i+1:2i]` is 2'b00 (single-rail NRZ) or 2'b01 (dual-rail NRZ), `drv_en[i]` goes to 0. It returns to 1 within a few cycles after edges resume.
- R6: A lost transmit clock has no effect on `drv_en[i]` while `remote_lb[i]` is 1, while `int_pat[i]` is 1, or while the format field is 2'b10 or 2'b11.
- R7: When `ch_rst[i]` is 1, `drv_en[i]` is 0 after the next edge.
- R8: When both `ocp_flag[i]` and `ocp_hiz_en[i]` are 1, `drv_en[i]` is 0 after the next edge. While `ocp_hiz_en[i]` is 0, `ocp_flag[i]` has no effect.
- R9: When `ch_pd[i]` is 1, `drv_en[i]`, `mf_en[i]` and `tx_ready[i]` are all 0 after the next edge.
- R10: After `ch_pd[i]` returns to 0, `tx_ready[i]` and `drv_en[i]` stay 0 for RECOVER_CYC cycles and then return to 1. `mf_en[i]` returns to 1 at the next edge.
- R11: If `mclk` shows no transition for MCLK_LOSS_CYC cycles, all drivers go to high impedance. They are enabled again within a few cycles after `mclk` edges resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock at the reference rate |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| oe_pin | input | 1 | Global output-enable pin; 0 forces high impedance |
| hw_rst_n | input | 1 | Hardware reset pin, active low, qualified by its pulse length |
| sw_rst | input | 1 | One-cycle global software reset pulse |
| mclk | input | 1 | Master clock, watched for loss |
| tx_clk | input | N_CH | Per-channel transmit clocks, watched for loss |
| ch_oe | input | N_CH | Per-channel output-enable bits |
| ch_pd | input | N_CH | Per-channel power-down bits |
| ch_rst | input | N_CH | Per-channel reset bits |
| ocp_flag | input | N_CH | Per-channel over-current indications |
| ocp_hiz_en | input | N_CH | Per-channel enables for over-current tri-state |
| remote_lb | input | N_CH | Per-channel remote loopback active |
| int_pat | input | N_CH | Per-channel internal pattern on the reference clock |
| tx_fmt | input | 2*N_CH | Per-channel 2-bit transmit format (00/01 NRZ, 10/11 other) |
| drv_en | output | N_CH | Per-channel line driver enable; 0 means high impedance |
| mf_en | output | N_CH | Per-channel multiframe output enable |
| tx_ready | output | N_CH | Per-channel transmitter steady-state flag |

## Verification
The bench builds the block with N_CH=4, MCLK_LOSS_CYC=40, RECOVER_CYC=30, SWRST_CYC=8, RST_MIN_CYC=4, and with the transmit-clock window kept at its true value of 64. The shortened windows bring master-clock loss, power-down recovery and both sides of the reset pulse qualifier into a short run. With four channels, the bench can show that a condition on one channel leaves its neighbours untouched. Samples are taken well inside and well outside each window, so the checks do not depend on the exact latency of the synchronizers.

// File: rtl/txo_pkg.sv
package txo_pkg;

   typedef enum logic [1:0] {
      FMT_NRZ_SR = 2'b00,
      FMT_NRZ_DR = 2'b01,
      FMT_RZ     = 2'b10,
      FMT_RSV    = 2'b11
   } txo_fmt_e;

   // The transmit clock is watched only for NRZ formats and only when the
   // channel really transmits on its own clock.
   function automatic logic clk_check_on(input txo_fmt_e fmt,
                                         input logic     loopback,
                                         input logic     int_pattern);
      return ((fmt == FMT_NRZ_SR) || (fmt == FMT_NRZ_DR)) && !loopback && !int_pattern;
   endfunction

endpackage

// File: rtl/txo_edge_watch.sv
module txo_edge_watch #(
   parameter int SYNC_STAGES = 2,
   parameter int LIMIT       = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic lost
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("txo_edge_watch: SYNC_STAGES must be at least 2");
   end
   if (LIMIT < 2) begin : g_bad_limit
      $error("txo_edge_watch: LIMIT must be at least 2");
   end

   logic [SYNC_STAGES:0] sh;
   logic [CW-1:0]        cnt;
   logic                 edge_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], sig_in};
   end

   assign edge_seen = sh[SYNC_STAGES] ^ sh[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (edge_seen)    cnt <= '0;
      else if (cnt != LIM)   cnt <= cnt + 1'b1;
   end

   assign lost = (cnt == LIM);

endmodule

// File: rtl/txo_rst_qual.sv
module txo_rst_qual #(
   parameter int MIN_LOW = 4,
   parameter int SW_HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic sw_pulse,
   output logic active
);
   localparam int LW = $clog2(MIN_LOW + 2);
   localparam int SW = $clog2(SW_HOLD + 1);
   localparam logic [LW-1:0] LOW_TOP = LW'(MIN_LOW + 1);
   localparam logic [SW-1:0] SW_TOP  = SW'(SW_HOLD);

   if (MIN_LOW < 1) begin : g_bad_min
      $error("txo_rst_qual: MIN_LOW must be at least 1");
   end
   if (SW_HOLD < 1) begin : g_bad_hold
      $error("txo_rst_qual: SW_HOLD must be at least 1");
   end

   logic [1:0]    pin_s;
   logic [LW-1:0] low_cnt;
   logic [SW-1:0] sw_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_s <= 2'b11;
      else        pin_s <= {pin_s[0], pin_n};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 low_cnt <= '0;
      else if (pin_s[1])          low_cnt <= '0;
      else if (low_cnt != LOW_TOP) low_cnt <= low_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           sw_cnt <= '0;
      else if (sw_pulse)    sw_cnt <= SW_TOP;
      else if (sw_cnt != 0) sw_cnt <= sw_cnt - 1'b1;
   end

   assign active = (low_cnt == LOW_TOP) || sw_pulse || (sw_cnt != '0);

endmodule

// File: rtl/txo_recover.sv
module txo_recover #(
   parameter int RECOVER_CYC = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd,
   output logic idle,
   output logic ready
);
   localparam int RW = $clog2(RECOVER_CYC + 1);
   localparam logic [RW-1:0] R_TOP = RW'(RECOVER_CYC);

   if (RECOVER_CYC < 2) begin : g_bad_rec
      $error("txo_recover: RECOVER_CYC must be at least 2");
   end

   logic [RW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (pd)        cnt <= R_TOP;
      else if (cnt != 0)  cnt <= cnt - 1'b1;
   end

   assign idle = !pd && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ready <= 1'b0;
      else        ready <= idle;
   end

endmodule

// File: rtl/txo_hiz_ctrl.sv
module txo_hiz_ctrl
   import txo_pkg::*;
#(
   parameter int N_CH          = 21,
   parameter int SYNC_STAGES   = 2,
   parameter int MCLK_LOSS_CYC = 2048,
   parameter int TXCLK_LOSS_CYC = 64,
   parameter int RST_MIN_CYC   = 4,
   parameter int SWRST_CYC     = 16,
   parameter int RECOVER_CYC   = 2048
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              oe_pin,
   input  logic              hw_rst_n,
   input  logic              sw_rst,
   input  logic              mclk,
   input  logic [N_CH-1:0]   tx_clk,
   input  logic [N_CH-1:0]   ch_oe,
   input  logic [N_CH-1:0]   ch_pd,
   input  logic [N_CH-1:0]   ch_rst,
   input  logic [N_CH-1:0]   ocp_flag,
   input  logic [N_CH-1:0]   ocp_hiz_en,
   input  logic [N_CH-1:0]   remote_lb,
   input  logic [N_CH-1:0]   int_pat,
   input  logic [2*N_CH-1:0] tx_fmt,
   output logic [N_CH-1:0]   drv_en,
   output logic [N_CH-1:0]   mf_en,
   output logic [N_CH-1:0]   tx_ready
);
   if (N_CH < 1 || N_CH > 64) begin : g_bad_nch
      $error("txo_hiz_ctrl: N_CH must lie in 1..64");
   end

   logic mclk_lost;
   logic rst_act;
   logic glob_hiz;

   txo_edge_watch #(.SYNC_STAGES(SYNC_STAGES), .LIMIT(MCLK_LOSS_CYC)) u_mclk_watch (
      .clk    (clk),
      .rst_n  (por_n),
      .sig_in (mclk),
      .lost   (mclk_lost)
   );

   txo_rst_qual #(.MIN_LOW(RST_MIN_CYC), .SW_HOLD(SWRST_CYC)) u_rst_qual (
      .clk      (clk),
      .rst_n    (por_n),
      .pin_n    (hw_rst_n),
      .sw_pulse (sw_rst),
      .active   (rst_act)
   );

   assign glob_hiz = !oe_pin || mclk_lost || rst_act;

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      logic     tclk_lost;
      logic     rec_idle;
      logic     ch_hiz;
      logic     drv_q;
      logic     mf_q;
      txo_fmt_e fmt;

      assign fmt = txo_fmt_e'(tx_fmt[2*i +: 2]);

      txo_edge_watch #(.SYNC_STAGES(SYNC_STAGES), .LIMIT(TXCLK_LOSS_CYC)) u_tclk_watch (
         .clk    (clk),
         .rst_n  (por_n),
         .sig_in (tx_clk[i]),
         .lost   (tclk_lost)
      );

      txo_recover #(.RECOVER_CYC(RECOVER_CYC)) u_recover (
         .clk   (clk),
         .rst_n (por_n),
         .pd    (ch_pd[i]),
         .idle  (rec_idle),
         .ready (tx_ready[i])
      );

      assign ch_hiz = !ch_oe[i] || !rec_idle || ch_rst[i]
                   || (ocp_flag[i] && ocp_hiz_en[i])
                   || (tclk_lost && clk_check_on(fmt, remote_lb[i], int_pat[i]));

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            drv_q <= 1'b0;
            mf_q  <= 1'b0;
         end else begin
            drv_q <= !(glob_hiz || ch_hiz);
            mf_q  <= !ch_pd[i];
         end
      end

      assign drv_en[i] = drv_q;
      assign mf_en[i]  = mf_q;
   end

endmodule

// File: rtl/txo_hiz_chk.sv
module txo_hiz_chk #(
   parameter int N_CH = 21
) (
   input logic            clk,
   input logic            por_n,
   input logic            oe_pin,
   input logic            sw_rst,
   input logic [N_CH-1:0] ch_oe,
   input logic [N_CH-1:0] ch_pd,
   input logic [N_CH-1:0] ch_rst,
   input logic [N_CH-1:0] ocp_flag,
   input logic [N_CH-1:0] ocp_hiz_en,
   input logic [N_CH-1:0] drv_en,
   input logic [N_CH-1:0] mf_en,
   input logic [N_CH-1:0] tx_ready
);
   a_r2_oe_pin_off: assert property (@(posedge clk) disable iff (!por_n)
      !oe_pin |=> (drv_en == '0));

   a_r3_sw_reset_off: assert property (@(posedge clk) disable iff (!por_n)
      sw_rst |=> (drv_en == '0));

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      a_r4_ch_oe_off: assert property (@(posedge clk) disable iff (!por_n)
         !ch_oe[i] |=> !drv_en[i]);

      a_r7_ch_rst_off: assert property (@(posedge clk) disable iff (!por_n)
         ch_rst[i] |=> !drv_en[i]);

      a_r8_ocp_off: assert property (@(posedge clk) disable iff (!por_n)
         (ocp_flag[i] && ocp_hiz_en[i]) |=> !drv_en[i]);

      a_r9_pd_off: assert property (@(posedge clk) disable iff (!por_n)
         ch_pd[i] |=> (!drv_en[i] && !mf_en[i] && !tx_ready[i]));

      a_r10_recover_wait: assert property (@(posedge clk) disable iff (!por_n)
         $fell(ch_pd[i]) |=> (!tx_ready[i] && !drv_en[i]));
   end

endmodule

bind txo_hiz_ctrl txo_hiz_chk #(.N_CH(N_CH)) u_hiz_chk (.*);

// File: tb/tb_txo_hiz_ctrl.sv
module tb_txo_hiz_ctrl;
   localparam int N = 4;
   localparam logic [N-1:0] F = '1;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic           por_n = 1'b0, oe_pin = 1'b1, hw_rst_n = 1'b1, sw_rst = 1'b0, mclk = 1'b0;
   logic [N-1:0]   tx_clk = '0, ch_oe = F, ch_pd = '0, ch_rst = '0;
   logic [N-1:0]   ocp_flag = '0, ocp_hiz_en = '0, remote_lb = '0, int_pat = '0;
   logic [2*N-1:0] tx_fmt = '0;
   logic [N-1:0]   drv_en, mf_en, tx_ready;

   logic           mrun = 1'b1;
   logic [N-1:0]   tx_run = F;

   always @(posedge clk) begin
      mclk   <= mrun ? ~mclk : mclk;
      tx_clk <= tx_clk ^ tx_run;
   end

   txo_hiz_ctrl #(
      .N_CH(N), .SYNC_STAGES(2), .MCLK_LOSS_CYC(40), .TXCLK_LOSS_CYC(64),
      .RST_MIN_CYC(4), .SWRST_CYC(8), .RECOVER_CYC(30)
   ) dut (
      .clk(clk), .por_n(por_n), .oe_pin(oe_pin), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst),
      .mclk(mclk), .tx_clk(tx_clk), .ch_oe(ch_oe), .ch_pd(ch_pd), .ch_rst(ch_rst),
      .ocp_flag(ocp_flag), .ocp_hiz_en(ocp_hiz_en), .remote_lb(remote_lb),
      .int_pat(int_pat), .tx_fmt(tx_fmt), .drv_en(drv_en), .mf_en(mf_en), .tx_ready(tx_ready)
   );

   typedef struct {
      logic [N-1:0] drv;
      logic [N-1:0] rdy;
      logic [N-1:0] mf;
      string        tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(input logic [N-1:0] drv, input logic [N-1:0] rdy,
                             input logic [N-1:0] mf, input string tag);
      exp_t e;
      e.drv = drv; e.rdy = rdy; e.mf = mf; e.tag = tag;
      q.push_back(e);
   endtask

   // Monitor: pops each expectation and compares it with the outputs.
   initial begin
      forever begin
         exp_t e;
         wait (q.size() != 0);
         e = q.pop_front();
         n_chk++;
         if (drv_en !== e.drv || tx_ready !== e.rdy || mf_en !== e.mf) begin
            n_bad++;
            $display("FAIL %s: actual drv=%b rdy=%b mf=%b expected drv=%b rdy=%b mf=%b",
                     e.tag, drv_en, tx_ready, mf_en, e.drv, e.rdy, e.mf);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog: actual still running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      step(3);
      expect_out('0, '0, '0, "R1 during reset");
      por_n = 1'b1;
      step(6);
      expect_out(F, F, F, "R1 after reset");

      oe_pin = 1'b0; step(2);
      expect_out('0, F, F, "R2 pin low");
      oe_pin = 1'b1; step(2);
      expect_out(F, F, F, "R2 pin high");

      ch_oe[1] = 1'b0; step(2);
      expect_out(4'b1101, F, F, "R4 ch1 enable bit");
      ch_oe[1] = 1'b1; step(2);

      ch_rst[2] = 1'b1; step(2);
      expect_out(4'b1011, F, F, "R7 ch2 reset");
      ch_rst[2] = 1'b0; step(2);

      ocp_flag[3] = 1'b1; step(3);
      expect_out(F, F, F, "R8 flag masked");
      ocp_hiz_en[3] = 1'b1; step(2);
      expect_out(4'b0111, F, F, "R8 flag enabled");
      ocp_flag[3] = 1'b0; ocp_hiz_en[3] = 1'b0; step(2);
      expect_out(F, F, F, "R8 cleared");

      hw_rst_n = 1'b0; step(3); hw_rst_n = 1'b1;
      for (int k = 0; k < 6; k++) begin
         step(1);
         expect_out(F, F, F, "R3 short pulse ignored");
      end
      hw_rst_n = 1'b0; step(10);
      expect_out('0, F, F, "R3 long pulse");
      hw_rst_n = 1'b1; step(5);
      expect_out(F, F, F, "R3 pin released");

      sw_rst = 1'b1; step(1); sw_rst = 1'b0; step(3);
      expect_out('0, F, F, "R3 software reset hold");
      step(12);
      expect_out(F, F, F, "R3 software reset over");

      tx_run[0] = 1'b0; step(40);
      expect_out(F, F, F, "R5 inside window");
      step(40);
      expect_out(4'b1110, F, F, "R5 clock lost");
      tx_run[0] = 1'b1; step(6);
      expect_out(F, F, F, "R5 clock resumed");

      remote_lb[0] = 1'b1; tx_run[0] = 1'b0; step(90);
      expect_out(F, F, F, "R6 loopback masks loss");
      remote_lb[0] = 1'b0; step(2);
      expect_out(4'b1110, F, F, "R5 loss seen after loopback");
      int_pat[0] = 1'b1; step(2);
      expect_out(F, F, F, "R6 internal pattern masks loss");
      int_pat[0] = 1'b0; tx_fmt[1:0] = 2'b10; step(2);
      expect_out(F, F, F, "R6 RZ format masks loss");
      tx_fmt[1:0] = 2'b00; tx_run[0] = 1'b1; step(6);
      expect_out(F, F, F, "R5 restored");

      mrun = 1'b0; step(20);
      expect_out(F, F, F, "R11 inside window");
      step(30);
      expect_out('0, F, F, "R11 master clock lost");
      mrun = 1'b1; step(6);
      expect_out(F, F, F, "R11 master clock resumed");

      ch_pd[1] = 1'b1; step(2);
      expect_out(4'b1101, 4'b1101, 4'b1101, "R9 power down");
      ch_pd[1] = 1'b0; step(10);
      expect_out(4'b1101, 4'b1101, F, "R10 recovering");
      step(30);
      expect_out(F, F, F, "R10 recovered");

      wait (q.size() == 0);
      step(1);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule